// File: doc/BRIEF.md
# Low-Power Wait Mode Controller

This block manages the two halt states of a small microcontroller core. When the core executes its wait instruction it raises a one-cycle strobe with a single operand bit. Operand 0 selects a light wait in which only the CPU clock stops. Operand 1 selects a deep wait in which the CPU and the display logic both stop, every LCD segment output is held low, and the PLL enable is withdrawn. The oscillator keeps running in both states.

While halted, the block watches its wake sources:
- a change of level on the hold pin;
- a high level on any key input, when key wake is enabled;
- the 2 Hz timer flag, in light wait only;
- a change of level on any port pin whose direction bit marks it as an input.

Hold, key and port levels pass through two-flop synchronisers. The hold and port levels are compared with a copy taken at entry, so a level that is already present when the wait starts does not release it. On release the block gives a one-clock resume pulse. In that same cycle every gating output is back at its run value, so the core can fetch the next instruction with no stabilisation delay.

Top module: `lpwait_ctrl`

## Requirements
- R1: After reset the block is running: cpu_clk_en=1, disp_clk_en=1, seg_out equals seg_data, pll_en equals pll_sw_on, and resume=0.
- R2: A wait_go strobe with wait_deep=0 enters light wait on that edge. From then on cpu_clk_en=0, while disp_clk_en=1, seg_out=seg_data and pll_en=pll_sw_on.
- R3: A wait_go strobe with wait_deep=1 enters deep wait on that edge. From then on cpu_clk_en=0, disp_clk_en=0, pll_en=0 and every seg_out bit is 0.
- R4: A change of level on hold_pin releases either wait. Resume is high in the third cycle after the input changes, which covers two synchroniser flops and the mode register.
- R5: A high level on any key_pins bit releases either wait with the same three-cycle latency when key_wake_en=1. It has no effect when key_wake_en=0.
- R6: tick_flag=1 releases light wait one cycle later. It is ignored in deep wait.
- R7: A change on port_pins[i] releases either wait with three-cycle latency only when port_dir_in[i]=1 (input). A change on a pin with direction bit 0 is ignored.
- R8: The hold level present at entry does not release the wait. Only a later change away from it does.
- R9: resume lasts exactly one clock. In that cycle cpu_clk_en=1 and all other gating outputs have their run values.
- R10: wait_go always enters the selected wait, even when a wake source is already active on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (oscillator domain) |
| rst | input | 1 | Synchronous active-high reset |
| wait_go | input | 1 | One-cycle wait instruction strobe |
| wait_deep | input | 1 | Wait operand: 0 light, 1 deep |
| hold_pin | input | 1 | Asynchronous hold input; any change wakes |
| key_pins | input | NUM_KEYS | Asynchronous key inputs; high wakes |
| key_wake_en | input | 1 | Key wake enable from key-input mode |
| tick_flag | input | 1 | 2 Hz timer flag, synchronous |
| port_pins | input | NUM_PORTS | Asynchronous port pin levels |
| port_dir_in | input | NUM_PORTS | Direction bits, 1 = input |
| pll_sw_on | input | 1 | Software PLL enable |
| seg_data | input | NUM_SEGS | LCD segment data from the display logic |
| cpu_clk_en | output | 1 | CPU clock enable |
| disp_clk_en | output | 1 | Display logic clock enable |
| pll_en | output | 1 | PLL enable after wait gating |
| seg_out | output | NUM_SEGS | LCD segment outputs, forced low in deep wait |
| resume | output | 1 | One-clock wake pulse |

## Verification
Suppose the mode register holds the wrong state. The gating outputs would show it on the first sample after the strobe edge: a light wait that stops the display, or a deep wait that leaves segments or the PLL on. A lost or stale entry reference appears as a resume pulse with no input change, or as a missing pulse in the third cycle after a real change. A mode-dependent filter error shows up as the timer flag waking deep wait, or as an output-direction pin waking either mode. Each of these appears within three cycles of the stimulus.

// File: rtl/lpwait_pkg.sv
package lpwait_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_LIGHT = 2'd1,
        MODE_DEEP  = 2'd2
    } wmode_e;

    typedef struct packed {
        logic hold;
        logic key;
        logic tick;
        logic port;
    } wake_src_t;

    typedef struct packed {
        logic cpu;
        logic disp;
        logic seg_pass;
        logic pll_allow;
    } gate_t;

    function automatic gate_t gate_for(wmode_e m);
        gate_t g;
        g.cpu       = (m == MODE_RUN);
        g.disp      = (m != MODE_DEEP);
        g.seg_pass  = (m != MODE_DEEP);
        g.pll_allow = (m != MODE_DEEP);
        return g;
    endfunction

    function automatic wmode_e mode_from_operand(logic deep);
        return deep ? MODE_DEEP : MODE_LIGHT;
    endfunction

endpackage

// File: rtl/lpwait_sync.sv
module lpwait_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lpwait_wake.sv
module lpwait_wake
    import lpwait_pkg::*;
#(
    parameter int NUM_KEYS  = 4,
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  wmode_e               mode,
    input  logic                 capture,
    input  logic                 hold_s,
    input  logic [NUM_KEYS-1:0]  key_s,
    input  logic                 key_wake_en,
    input  logic                 tick_flag,
    input  logic [NUM_PORTS-1:0] port_s,
    input  logic [NUM_PORTS-1:0] port_dir_in,
    output wake_src_t            src,
    output logic                 hit
);
    logic                 hold_ref;
    logic [NUM_PORTS-1:0] port_ref;
    logic [NUM_PORTS-1:0] port_diff;
    logic                 halted;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_ref <= 1'b0;
            port_ref <= '0;
        end else if (capture) begin
            hold_ref <= hold_s;
            port_ref <= port_s;
        end
    end

    generate
        for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
            assign port_diff[i] = (port_s[i] ^ port_ref[i]) & port_dir_in[i];
        end
    endgenerate

    assign halted = (mode != MODE_RUN);

    always_comb begin
        src.hold = halted && (hold_s != hold_ref);
        src.key  = halted && key_wake_en && (|key_s);
        src.tick = (mode == MODE_LIGHT) && tick_flag;
        src.port = halted && (|port_diff);
        hit      = |src;
    end

    // R6: the timer flag never counts as a wake source in deep wait
    a_r6_tick_not_deep: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DEEP) |-> !src.tick);
    // R7: a pin marked as output never contributes a port wake
    a_r7_port_dir_mask: assert property (@(posedge clk) disable iff (rst)
        (port_dir_in == '0) |-> !src.port);
endmodule

// File: rtl/lpwait_fsm.sv
module lpwait_fsm
    import lpwait_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wait_go,
    input  logic   wait_deep,
    input  logic   wake_hit,
    output wmode_e mode,
    output logic   capture,
    output logic   resume
);
    wmode_e mode_q;

    assign capture = wait_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RUN;
            resume <= 1'b0;
        end else if (wait_go) begin
            mode_q <= mode_from_operand(wait_deep);
            resume <= 1'b0;
        end else if (mode_q != MODE_RUN && wake_hit) begin
            mode_q <= MODE_RUN;
            resume <= 1'b1;
        end else begin
            resume <= 1'b0;
        end
    end

    assign mode = mode_q;

    // R9: resume is a single-cycle pulse
    a_r9_pulse_one: assert property (@(posedge clk) disable iff (rst)
        resume |=> !resume);
    // R9: the core is running again while resume is high
    a_r9_run_on_resume: assert property (@(posedge clk) disable iff (rst)
        resume |-> (mode_q == MODE_RUN));
    // R10: a strobe always lands in a halt state
    a_r10_entry_wins: assert property (@(posedge clk) disable iff (rst)
        wait_go |=> (mode_q != MODE_RUN));
endmodule

// File: rtl/lpwait_ctrl.sv
module lpwait_ctrl
    import lpwait_pkg::*;
#(
    parameter int NUM_KEYS    = 4,
    parameter int NUM_PORTS   = 4,
    parameter int NUM_SEGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wait_go,
    input  logic                 wait_deep,
    input  logic                 hold_pin,
    input  logic [NUM_KEYS-1:0]  key_pins,
    input  logic                 key_wake_en,
    input  logic                 tick_flag,
    input  logic [NUM_PORTS-1:0] port_pins,
    input  logic [NUM_PORTS-1:0] port_dir_in,
    input  logic                 pll_sw_on,
    input  logic [NUM_SEGS-1:0]  seg_data,
    output logic                 cpu_clk_en,
    output logic                 disp_clk_en,
    output logic                 pll_en,
    output logic [NUM_SEGS-1:0]  seg_out,
    output logic                 resume
);
    localparam int SYNC_W = 1 + NUM_KEYS + NUM_PORTS;

    logic [SYNC_W-1:0]    raw_bus, sync_bus;
    logic                 hold_s;
    logic [NUM_KEYS-1:0]  key_s;
    logic [NUM_PORTS-1:0] port_s;
    wmode_e               mode;
    wake_src_t            src;
    logic                 hit, capture;
    gate_t                gate;

    assign raw_bus = {hold_pin, key_pins, port_pins};

    lpwait_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_bus), .q(sync_bus)
    );

    assign {hold_s, key_s, port_s} = sync_bus;

    lpwait_wake #(.NUM_KEYS(NUM_KEYS), .NUM_PORTS(NUM_PORTS)) u_wake (
        .clk(clk), .rst(rst), .mode(mode), .capture(capture),
        .hold_s(hold_s), .key_s(key_s), .key_wake_en(key_wake_en),
        .tick_flag(tick_flag), .port_s(port_s), .port_dir_in(port_dir_in),
        .src(src), .hit(hit)
    );

    lpwait_fsm u_fsm (
        .clk(clk), .rst(rst), .wait_go(wait_go), .wait_deep(wait_deep),
        .wake_hit(hit), .mode(mode), .capture(capture), .resume(resume)
    );

    always_comb begin
        gate        = gate_for(mode);
        cpu_clk_en  = gate.cpu;
        disp_clk_en = gate.disp;
        pll_en      = pll_sw_on && gate.pll_allow;
        seg_out     = gate.seg_pass ? seg_data : '0;
    end

    // R3: with display stopped, segments are low and the PLL is off
    a_r3_deep_outputs: assert property (@(posedge clk) disable iff (rst)
        (!disp_clk_en) |-> (seg_out == '0 && !pll_en && !cpu_clk_en));
    // R2: light wait leaves segments and PLL under normal control
    a_r2_light_passthru: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && disp_clk_en) |-> (seg_out == seg_data && pll_en == pll_sw_on));
    // R10: the CPU clock stops on the cycle after any strobe
    a_r10_cpu_stops: assert property (@(posedge clk) disable iff (rst)
        wait_go |=> !cpu_clk_en);
endmodule

// File: tb/lpwait_ctrl_test.sv
module lpwait_ctrl_test;
    localparam int NK = 4, NP = 4, NS = 8;

    logic clk = 1'b0;
    logic rst;
    logic wait_go, wait_deep, hold_pin, key_wake_en, tick_flag, pll_sw_on;
    logic [NK-1:0] key_pins;
    logic [NP-1:0] port_pins, port_dir_in;
    logic [NS-1:0] seg_data, seg_out;
    logic cpu_clk_en, disp_clk_en, pll_en, resume;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lpwait_ctrl #(.NUM_KEYS(NK), .NUM_PORTS(NP), .NUM_SEGS(NS)) uut (
        .clk(clk), .rst(rst), .wait_go(wait_go), .wait_deep(wait_deep),
        .hold_pin(hold_pin), .key_pins(key_pins), .key_wake_en(key_wake_en),
        .tick_flag(tick_flag), .port_pins(port_pins), .port_dir_in(port_dir_in),
        .pll_sw_on(pll_sw_on), .seg_data(seg_data), .cpu_clk_en(cpu_clk_en),
        .disp_clk_en(disp_clk_en), .pll_en(pll_en), .seg_out(seg_out),
        .resume(resume)
    );

    // vector: [4]=deep, [3:1]=source, [0]=wake expected
    // sources: 0 hold toggle, 1 key with enable, 2 key without enable,
    //          3 timer flag, 4 input-direction port pin, 5 output-direction port pin
    localparam int NV = 9;
    localparam logic [4:0] VEC [NV] = '{
        {1'b0, 3'd0, 1'b1},
        {1'b1, 3'd0, 1'b1},
        {1'b0, 3'd1, 1'b1},
        {1'b1, 3'd1, 1'b1},
        {1'b1, 3'd2, 1'b0},
        {1'b0, 3'd3, 1'b1},
        {1'b1, 3'd3, 1'b0},
        {1'b1, 3'd4, 1'b1},
        {1'b0, 3'd5, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic defaults();
        wait_go = 0; wait_deep = 0; hold_pin = 0; key_pins = '0;
        key_wake_en = 0; tick_flag = 0; port_pins = '0; port_dir_in = '0;
        pll_sw_on = 1; seg_data = 8'hA5;
    endtask

    task automatic do_reset();
        @(negedge clk); defaults(); rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic enter(input logic deep);
        wait_go = 1; wait_deep = deep;
        @(negedge clk);
        wait_go = 0;
    endtask

    // returns cycle index (1..N) at which resume was seen, 0 if none
    task automatic watch(input int n, output int at, output bit one_cycle, output bit run_ok);
        at = 0; one_cycle = 1; run_ok = 1;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (resume) begin
                if (at != 0) one_cycle = 0;
                else begin
                    at = k;
                    run_ok = cpu_clk_en && disp_clk_en && pll_en && (seg_out == seg_data);
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        int at;
        bit one, runok;
        rst = 1; defaults();
        do_reset();

        // R1 reset state
        check(cpu_clk_en && disp_clk_en && !resume, "R1 run gates", {cpu_clk_en, disp_clk_en, resume}, 3'b110);
        check(seg_out == seg_data && pll_en == 1'b1, "R1 seg/pll", {pll_en, seg_out}, {1'b1, seg_data});

        for (int v = 0; v < NV; v++) begin
            logic deep; logic [2:0] srcsel; logic expw; int lat;
            deep = VEC[v][4]; srcsel = VEC[v][3:1]; expw = VEC[v][0];
            lat = (srcsel == 3'd3) ? 1 : 3;
            do_reset();
            if (srcsel == 3'd1) key_wake_en = 1;
            if (srcsel == 3'd4) port_dir_in = 4'b0001;
            if (srcsel == 3'd5) port_dir_in = 4'b1110;
            enter(deep);
            if (deep)
                check(!cpu_clk_en && !disp_clk_en && !pll_en && seg_out == '0, "R3 deep gating",
                      {cpu_clk_en, disp_clk_en, pll_en, seg_out}, 0);
            else
                check(!cpu_clk_en && disp_clk_en && pll_en && seg_out == seg_data, "R2 light gating",
                      {cpu_clk_en, disp_clk_en, pll_en, seg_out}, {3'b011, seg_data});
            case (srcsel)
                3'd0: hold_pin = 1;
                3'd1, 3'd2: key_pins = 4'b0100;
                3'd3: tick_flag = 1;
                default: port_pins = 4'b0001;
            endcase
            watch(6, at, one, runok);
            case (srcsel)
                3'd0: check(at == (expw ? lat : 0), "R4 hold wake", at, expw ? lat : 0);
                3'd1, 3'd2: check(at == (expw ? lat : 0), "R5 key wake", at, expw ? lat : 0);
                3'd3: check(at == (expw ? lat : 0), "R6 tick wake", at, expw ? lat : 0);
                default: check(at == (expw ? lat : 0), "R7 port wake", at, expw ? lat : 0);
            endcase
            if (expw) begin
                check(one, "R9 pulse width", one, 1);
                check(runok, "R9 run on resume", runok, 1);
            end else begin
                check(!cpu_clk_en, "R5/R6/R7 still halted", cpu_clk_en, 0);
            end
        end

        // R8: hold already high at entry must not wake; later change does
        do_reset();
        hold_pin = 1;
        repeat (4) @(negedge clk);
        enter(1'b1);
        watch(6, at, one, runok);
        check(at == 0 && !cpu_clk_en, "R8 entry level ignored", at, 0);
        hold_pin = 0;
        watch(6, at, one, runok);
        check(at == 3, "R8 later change wakes", at, 3);

        // R10: strobe with timer flag already high still enters light wait
        do_reset();
        tick_flag = 1;
        enter(1'b0);
        check(!cpu_clk_en, "R10 entry with active source", cpu_clk_en, 0);
        watch(3, at, one, runok);
        check(at == 1, "R10 then wakes", at, 1);

        // R7: output pin change then input pin change in deep wait
        do_reset();
        port_dir_in = 4'b1000;
        enter(1'b1);
        port_pins = 4'b0111;
        watch(5, at, one, runok);
        check(at == 0, "R7 output pins ignored", at, 0);
        port_pins = 4'b1111;
        watch(5, at, one, runok);
        check(at == 3, "R7 input pin wakes", at, 3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule